// File: doc/BRIEF.md
# Open-Drain Data Line Direction Arbiter

This block joins a host-side open-drain data line to a card-side open-drain data line and decides, transfer by transfer, which side is the source. Both lines are sampled through two-flop synchronisers. While the lines are neutral, the side whose line is seen falling first becomes the input. After a programmable delay, the block pulls the opposite line low. When the input line rises again, the block releases the pull and goes back to neutral, ready for a transfer in either direction.

A sequencer enable gates the whole function. While the enable is low, the card-side line is held low and the host-side line is released. Arbitration runs only while the enable is high. Dropping the enable at any time forces the held state on the next clock edge. The top module carries a parameterised number of independent lanes, for example one main data line and two auxiliary lines.

Top module: `iodir_arbiter`

## Requirements
- R1: While `rst` is high, and on the first edge after it, every lane has `card_pull` = 1 and `host_pull` = 0.
- R2: While `rx_en` is 0, every lane holds `card_pull` = 1 and `host_pull` = 0, whatever the lines do. One edge after `rx_en` is sampled at 1, `card_pull` drops to 0 on every lane.
- R3: In the neutral state, a host line fall makes the host side the input. `card_pull` rises on the fifth rising edge after the input change: two synchroniser edges, one detect edge, and FALL_CYC = 2 delay edges. `host_pull` stays 0.
- R4: In the neutral state, a card line fall makes the card side the input. With the same five-edge latency, `host_pull` rises and `card_pull` stays 0.
- R5: When the input line rises, the output pull is released on the third rising edge after the change, with RISE_CYC = 0. The lane is then neutral again.
- R6: If both lines fall in the same sample cycle, the host side wins: `card_pull` rises and `host_pull` stays 0.
- R7: The line being driven is ignored while it is the output. Its low level, and its rise after release, start no new transfer. A transfer in the opposite direction works right after the return to neutral.
- R8: If `rx_en` falls during a transfer, the lane goes to `card_pull` = 1 and `host_pull` = 0 on the next edge.
- R9: A lane never has `host_pull` and `card_pull` both at 1.
- R10: Lanes are independent: each lane can be in a different direction at the same time.
- R11: An input low pulse that ends before the fall delay expires, such as a one-cycle low, pulls neither side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable from the sequencer |
| host_in | input | LANES | Sampled host-side line levels |
| card_in | input | LANES | Sampled card-side line levels |
| host_pull | output | LANES | 1 = pull host-side line low |
| card_pull | output | LANES | 1 = pull card-side line low |

## Verification
The hardest situation to reach is the echo case. The block's own pull makes the output line fall, and the line rises again when the pull is released. Neither event may start a new transfer. The bench models both lines as wired-AND of an external driver and the block's pull, so the echo happens naturally. After each release, the bench checks that the lane stays neutral and then starts a transfer in the reverse direction. Same-cycle falls and one-cycle glitches are produced by driving both lines on the same half-cycle, or for exactly one clock.

// File: rtl/iodir_pkg.sv
package iodir_pkg;
  // Per-lane arbitration phase
  typedef enum logic [2:0] {
    PH_HOLD   = 3'd0,  // card line held low, waiting for enable
    PH_IDLE   = 3'd1,  // both released, watching for a first fall
    PH_FALL   = 3'd2,  // winner chosen, fall delay running
    PH_ACTIVE = 3'd3,  // output side pulled low
    PH_RISE   = 3'd4   // input rose, optional release delay
  } phase_t;

  // Which side is the input of the current transfer
  typedef enum logic {
    SRC_HOST = 1'b0,
    SRC_CARD = 1'b1
  } src_t;
endpackage

// File: rtl/iodir_sync.sv
module iodir_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shreg;

  // Lines idle high, so the chain resets to 1
  always_ff @(posedge clk) begin
    if (rst) shreg <= '1;
    else     shreg <= {shreg[STAGES-2:0], din};
  end

  assign dout = shreg[STAGES-1];
endmodule

// File: rtl/iodir_lane.sv
module iodir_lane
  import iodir_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FALL_CYC    = 2,
  parameter int RISE_CYC    = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_en,
  input  logic host_in,
  input  logic card_in,
  output logic host_pull,
  output logic card_pull
);
  localparam int MAX_CYC  = (FALL_CYC > RISE_CYC) ? FALL_CYC : RISE_CYC;
  localparam int CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam int FALL_LDI = (FALL_CYC > 0) ? FALL_CYC - 1 : 0;
  localparam int RISE_LDI = (RISE_CYC > 0) ? RISE_CYC - 1 : 0;
  localparam logic [CNT_W-1:0] FALL_LD = CNT_W'(FALL_LDI);
  localparam logic [CNT_W-1:0] RISE_LD = CNT_W'(RISE_LDI);
  localparam bit HAS_RISE = (RISE_CYC > 0);

  logic host_s, card_s;
  logic host_q, card_q;
  logic host_fall, card_fall;
  logic win_high;

  phase_t           ph, ph_n;
  src_t             src, src_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             host_pull_n, card_pull_n;

  iodir_sync #(.STAGES(SYNC_STAGES)) u_sync_host (
    .clk(clk), .rst(rst), .din(host_in), .dout(host_s)
  );
  iodir_sync #(.STAGES(SYNC_STAGES)) u_sync_card (
    .clk(clk), .rst(rst), .din(card_in), .dout(card_s)
  );

  // Previous synchronised levels for fall detection
  always_ff @(posedge clk) begin
    if (rst) begin
      host_q <= 1'b1;
      card_q <= 1'b1;
    end else begin
      host_q <= host_s;
      card_q <= card_s;
    end
  end

  assign host_fall = host_q & ~host_s;
  assign card_fall = card_q & ~card_s;
  // Only the winner's level is watched after a choice is made
  assign win_high  = (src == SRC_HOST) ? host_s : card_s;

  always_comb begin
    ph_n  = ph;
    src_n = src;
    cnt_n = cnt;
    if (!rx_en) begin
      ph_n = PH_HOLD;
    end else begin
      case (ph)
        PH_HOLD: ph_n = PH_IDLE;
        PH_IDLE: begin
          if (host_fall) begin
            ph_n  = PH_FALL;
            src_n = SRC_HOST;
            cnt_n = FALL_LD;
          end else if (card_fall) begin
            ph_n  = PH_FALL;
            src_n = SRC_CARD;
            cnt_n = FALL_LD;
          end
        end
        PH_FALL: begin
          if (win_high)        ph_n  = PH_IDLE;
          else if (cnt == '0)  ph_n  = PH_ACTIVE;
          else                 cnt_n = cnt - 1'b1;
        end
        PH_ACTIVE: begin
          if (win_high) begin
            if (HAS_RISE) begin
              ph_n  = PH_RISE;
              cnt_n = RISE_LD;
            end else begin
              ph_n = PH_IDLE;
            end
          end
        end
        PH_RISE: begin
          if (cnt == '0) ph_n  = PH_IDLE;
          else           cnt_n = cnt - 1'b1;
        end
        default: ph_n = PH_HOLD;
      endcase
    end
  end

  // Output pulls follow the next phase so they are registered
  always_comb begin
    host_pull_n = 1'b0;
    card_pull_n = 1'b0;
    if (ph_n == PH_HOLD) begin
      card_pull_n = 1'b1;
    end else if (ph_n == PH_ACTIVE || ph_n == PH_RISE) begin
      if (src_n == SRC_HOST) card_pull_n = 1'b1;
      else                   host_pull_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_HOLD;
      src       <= SRC_HOST;
      cnt       <= '0;
      host_pull <= 1'b0;
      card_pull <= 1'b1;
    end else begin
      ph        <= ph_n;
      src       <= src_n;
      cnt       <= cnt_n;
      host_pull <= host_pull_n;
      card_pull <= card_pull_n;
    end
  end
endmodule

// File: rtl/iodir_arbiter.sv
module iodir_arbiter #(
  parameter int LANES       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FALL_CYC    = 2,
  parameter int RISE_CYC    = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic [LANES-1:0] host_in,
  input  logic [LANES-1:0] card_in,
  output logic [LANES-1:0] host_pull,
  output logic [LANES-1:0] card_pull
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    iodir_lane #(
      .SYNC_STAGES(SYNC_STAGES),
      .FALL_CYC   (FALL_CYC),
      .RISE_CYC   (RISE_CYC)
    ) u_lane (
      .clk      (clk),
      .rst      (rst),
      .rx_en    (rx_en),
      .host_in  (host_in[i]),
      .card_in  (card_in[i]),
      .host_pull(host_pull[i]),
      .card_pull(card_pull[i])
    );
  end
endmodule

// File: rtl/iodir_arbiter_chk.sv
module iodir_arbiter_chk #(
  parameter int LANES = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_en,
  input logic [LANES-1:0] host_in,
  input logic [LANES-1:0] card_in,
  input logic [LANES-1:0] host_pull,
  input logic [LANES-1:0] card_pull
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (card_pull == {LANES{1'b1}} && host_pull == '0))
    else $error("reset_state_chk");

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (card_pull == {LANES{1'b1}} && host_pull == '0))
    else $error("hold_when_off_chk");

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R9
    one_side_chk: assert property (@(posedge clk) disable iff (rst)
      !(host_pull[g] && card_pull[g]))
      else $error("one_side_chk lane %0d", g);

    // R2
    host_drive_enabled_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(host_pull[g]) |-> ($past(rx_en) && rx_en))
      else $error("host_drive_enabled_chk lane %0d", g);

    // R8
    drop_release_host_chk: assert property (@(posedge clk) disable iff (rst)
      (host_pull[g] && !rx_en) |=> !host_pull[g])
      else $error("drop_release_host_chk lane %0d", g);
  end

  logic unused_in;
  assign unused_in = ^{host_in, card_in};
endmodule

bind iodir_arbiter iodir_arbiter_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/iodir_arbiter_bench.sv
module iodir_arbiter_bench;
  localparam int LANES = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rx_en = 1'b0;
  logic [LANES-1:0] host_ext = '1;
  logic [LANES-1:0] card_ext = '1;
  logic [LANES-1:0] host_pull, card_pull;
  logic [LANES-1:0] host_line, card_line;

  int checks = 0;
  int errors = 0;

  // Wired-AND model of the open-drain lines
  assign host_line = host_ext & ~host_pull;
  assign card_line = card_ext & ~card_pull;

  always #10 clk = ~clk;

  iodir_arbiter #(.LANES(LANES)) u_iodir_arbiter (
    .clk(clk), .rst(rst), .rx_en(rx_en),
    .host_in(host_line), .card_in(card_line),
    .host_pull(host_pull), .card_pull(card_pull)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset_hold;
    rst = 1'b1; rx_en = 1'b0;
    step(3);
    chk("R1 reset card_pull", 32'(card_pull), 32'h7);
    chk("R1 reset host_pull", 32'(host_pull), 32'h0);
    rst = 1'b0;
    step(1);
    chk("R1 after reset", 32'({host_pull, card_pull}), 32'h07);
    host_ext = 3'b000;
    step(8);
    chk("R2 hold ignores host fall", 32'({host_pull, card_pull}), 32'h07);
    host_ext = 3'b111;
    step(4);
    rx_en = 1'b1;
    step(1);
    chk("R2 enable releases card", 32'({host_pull, card_pull}), 32'h00);
    step(6);
    chk("R2 neutral after card rises", 32'({host_pull, card_pull}), 32'h00);
  endtask

  task automatic t_host_to_card;
    host_ext[0] = 1'b0;
    step(4);
    chk("R3 no drive before delay", 32'(card_pull[0]), 32'h0);
    step(1);
    chk("R3 card pulled on fifth edge", 32'(card_pull[0]), 32'h1);
    chk("R3 host side released", 32'(host_pull[0]), 32'h0);
    chk("R9 exclusive", 32'(host_pull & card_pull), 32'h0);
    host_ext[0] = 1'b1;
    step(2);
    chk("R5 still pulled before release", 32'(card_pull[0]), 32'h1);
    step(1);
    chk("R5 release on third edge", 32'(card_pull[0]), 32'h0);
  endtask

  task automatic t_echo;
    // r7_ echo of the released card line must not start a transfer
    step(8);
    chk("R7 neutral after echo", 32'({host_pull, card_pull}), 32'h00);
    card_ext[0] = 1'b0;
    step(5);
    chk("R7 reverse transfer after echo", 32'(host_pull[0]), 32'h1);
    chk("R7 card side not pulled", 32'(card_pull[0]), 32'h0);
    card_ext[0] = 1'b1;
    step(3);
    chk("R5 host release", 32'(host_pull[0]), 32'h0);
    step(8);
    chk("R7 neutral after host echo", 32'({host_pull, card_pull}), 32'h00);
  endtask

  task automatic t_card_to_host;
    card_ext[2] = 1'b0;
    step(4);
    chk("R4 no drive before delay", 32'(host_pull[2]), 32'h0);
    step(1);
    chk("R4 host pulled", 32'(host_pull[2]), 32'h1);
    chk("R4 card side released", 32'(card_pull[2]), 32'h0);
    card_ext[2] = 1'b1;
    step(3);
    chk("R5 card input rise releases", 32'(host_pull[2]), 32'h0);
    step(6);
  endtask

  task automatic t_same_cycle;
    host_ext[1] = 1'b0;
    card_ext[1] = 1'b0;
    step(5);
    chk("R6 host wins card pulled", 32'(card_pull[1]), 32'h1);
    chk("R6 host not pulled", 32'(host_pull[1]), 32'h0);
    step(2);
    chk("R6 direction holds", 32'({host_pull[1], card_pull[1]}), 32'h1);
    card_ext[1] = 1'b1;
    host_ext[1] = 1'b1;
    step(3);
    chk("R6 release after host rise", 32'({host_pull[1], card_pull[1]}), 32'h0);
    step(8);
  endtask

  task automatic t_glitch;
    host_ext[0] = 1'b0;
    step(1);
    host_ext[0] = 1'b1;
    for (int k = 0; k < 8; k++) begin
      step(1);
      if (card_pull[0] !== 1'b0) chk("R11 glitch drove card", 32'(card_pull[0]), 32'h0);
    end
    chk("R11 glitch ignored", 32'({host_pull, card_pull}), 32'h00);
  endtask

  task automatic t_disable;
    host_ext[0] = 1'b0;
    step(6);
    chk("R8 active before drop", 32'(card_pull[0]), 32'h1);
    rx_en = 1'b0;
    step(1);
    chk("R8 hold state", 32'({host_pull, card_pull}), 32'h07);
    host_ext[0] = 1'b1;
    step(4);
    rx_en = 1'b1;
    step(6);
    chk("R8 neutral after re-enable", 32'({host_pull, card_pull}), 32'h00);
  endtask

  task automatic t_lanes;
    host_ext[0] = 1'b0;
    card_ext[2] = 1'b0;
    step(5);
    chk("R10 lane directions card", 32'(card_pull), 32'h1);
    chk("R10 lane directions host", 32'(host_pull), 32'h4);
    chk("R9 exclusive lanes", 32'(host_pull & card_pull), 32'h0);
    host_ext[0] = 1'b1;
    card_ext[2] = 1'b1;
    step(3);
    chk("R10 all released", 32'({host_pull, card_pull}), 32'h00);
  endtask

  initial begin
    #2;
    t_reset_hold();
    t_host_to_card();
    t_echo();
    t_card_to_host();
    t_same_cycle();
    t_glitch();
    t_disable();
    t_lanes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule